// File: doc/BRIEF.md
# Correlating One-Bit Branch Direction Predictor

This block predicts taken or not taken for conditional branches. It combines a small table of one-bit predictors with one bit of global history. The history bit holds the outcome of the branch that resolved most recently, whichever branch that was. Each table row holds two one-bit predictions. The row is chosen by PC bits [5:2], and the history bit chooses which of the row's two predictions applies.

A fetch stage raises `lookup_vld` with a PC and receives the direction in the same cycle. When a branch resolves, the execute stage raises `resolve_vld` with the branch PC and its actual outcome. The block then corrects the prediction it would have used for that branch and records the outcome as the new history. Mispredictions found at resolve time are counted in a saturating counter.

Top module: `corr_bpred`

## Requirements
- R1: After a synchronous active-high reset, every prediction bit and the history bit are not taken (0), and `miss_count` is 0.
- R2: `lookup_taken` is combinational from `lookup_pc` in the same cycle. It is the bit of row `lookup_pc[5:2]` selected by the history bit: column 0 when the last outcome was not taken, column 1 when it was taken. It is 0 whenever `lookup_vld` is low. Taken is encoded as 1.
- R3: On each cycle with `resolve_vld` high, the history bit becomes `resolve_taken` at the next clock edge.
- R4: A resolve selects its column using the history value from before that resolve, not the outcome it is writing.
- R5: If the selected bit differs from `resolve_taken`, that single bit is flipped. If it matches, nothing in the table changes. No other row or column is touched.
- R6: When a lookup and a resolve happen in the same cycle, the lookup sees the table and history as they were before the resolve.
- R7: PCs that share bits [5:2] share one table row. All other PC bits have no effect on lookups or resolves.
- R8: `miss_count` increments by one at the edge after each resolve whose selected bit differed from `resolve_taken`. It is unchanged otherwise.
- R9: `miss_count` saturates at 16'hFFFF and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_vld | input | 1 | Lookup strobe |
| lookup_pc | input | 32 | PC of the branch being predicted |
| lookup_taken | output | 1 | Predicted direction, 1 = taken |
| resolve_vld | input | 1 | Resolve strobe |
| resolve_pc | input | 32 | PC of the resolved branch |
| resolve_taken | input | 1 | Actual outcome, 1 = taken |
| miss_count | output | 16 | Saturating count of mispredicted resolves |

## Verification
The assertions take for granted that `resolve_vld` and `resolve_taken` are known, two-valued levels at every clock edge once reset has been released. They also take for granted that the resolve PC never carries unknown bits in its index field. The stimulus drives every input from defined values on the falling edge. It holds reset across at least one rising edge before any traffic. It reuses a small set of PCs that alias on bits [5:2] and differ in their upper bits, so rows are shared without any unknown input ever reaching the block.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;
  typedef enum logic {DIR_NT = 1'b0, DIR_T = 1'b1} dir_e;

  // a stored guess disagrees with the resolved outcome
  function automatic logic is_miss(input logic guess, input logic actual);
    return guess ^ actual;
  endfunction

  // row select taken from the word-aligned PC bits
  function automatic logic [3:0] row_of(input logic [31:0] pc);
    return pc[5:2];
  endfunction
endpackage

// File: rtl/corr_bpred_hist.sv
module corr_bpred_hist (
  input  logic clk,
  input  logic rst,
  input  logic upd_vld,
  input  logic upd_taken,
  output logic hist
);
  always_ff @(posedge clk) begin
    if (rst)          hist <= 1'b0;
    else if (upd_vld) hist <= upd_taken;
  end

  AST_HIST_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    upd_vld |=> hist == $past(upd_taken)); // R3
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_vld |=> $stable(hist)); // R3
endmodule

// File: rtl/corr_bpred_table.sv
module corr_bpred_table #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] rd_row,
  input  logic             rd_col,
  output logic             rd_bit,
  input  logic             wr_vld,
  input  logic [ROW_W-1:0] wr_row,
  input  logic             wr_col,
  input  logic             wr_actual,
  output logic             wr_miss
);
  import corr_bpred_pkg::*;
  localparam int ROWS  = 1 << ROW_W;
  localparam int NBITS = 2 * ROWS;

  logic [NBITS-1:0] bits_q;
  logic             wr_old;
  logic             flip_en;

  assign rd_bit  = bits_q[{rd_row, rd_col}];
  assign wr_old  = bits_q[{wr_row, wr_col}];
  assign wr_miss = wr_vld & is_miss(wr_old, wr_actual);
  assign flip_en = wr_miss;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < 2; c++) begin : g_col
      always_ff @(posedge clk) begin
        if (rst) bits_q[2*r+c] <= 1'b0;
        else if (flip_en && wr_row == ROW_W'(r) && wr_col == 1'(c))
          bits_q[2*r+c] <= ~bits_q[2*r+c];
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> bits_q == '0); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_vld |=> bits_q[$past({wr_row, wr_col})] == $past(wr_actual)); // R5
  AST_HIT_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !wr_miss |=> $stable(bits_q)); // R5
  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    wr_miss |=> $countones(bits_q ^ $past(bits_q)) == 1); // R5
endmodule

// File: rtl/corr_bpred_misscnt.sv
module corr_bpred_misscnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic at_top;
  assign at_top = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (inc && !at_top) cnt <= cnt + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    at_top |=> cnt == TOP); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !at_top) |=> cnt == $past(cnt) + 1'b1); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt)); // R8
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W    = 32,
  parameter int ROW_W   = 4,
  parameter int ROW_LSB = 2,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lookup_vld,
  input  logic [PC_W-1:0]  lookup_pc,
  output logic             lookup_taken,
  input  logic             resolve_vld,
  input  logic [PC_W-1:0]  resolve_pc,
  input  logic             resolve_taken,
  output logic [CNT_W-1:0] miss_count
);
  localparam int ROW_MSB = ROW_LSB + ROW_W - 1;

  logic             hist;
  logic             rd_bit;
  logic             miss_ev;
  logic [ROW_W-1:0] lk_row;
  logic [ROW_W-1:0] rs_row;
  logic             unused_pc_bits;

  assign lk_row = lookup_pc[ROW_MSB:ROW_LSB];
  assign rs_row = resolve_pc[ROW_MSB:ROW_LSB];
  assign unused_pc_bits = ^{lookup_pc[PC_W-1:ROW_MSB+1], lookup_pc[ROW_LSB-1:0],
                            resolve_pc[PC_W-1:ROW_MSB+1], resolve_pc[ROW_LSB-1:0]};

  corr_bpred_hist u_hist (
    .clk(clk), .rst(rst), .upd_vld(resolve_vld), .upd_taken(resolve_taken), .hist(hist)
  );

  corr_bpred_table #(.ROW_W(ROW_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_row(lk_row), .rd_col(hist), .rd_bit(rd_bit),
    .wr_vld(resolve_vld), .wr_row(rs_row), .wr_col(hist),
    .wr_actual(resolve_taken), .wr_miss(miss_ev)
  );

  corr_bpred_misscnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(miss_ev), .cnt(miss_count)
  );

  assign lookup_taken = lookup_vld & rd_bit;

  AST_MISS_NEEDS_RESOLVE: assert property (@(posedge clk) disable iff (rst)
    !resolve_vld |-> !miss_ev); // R8
  AST_RESET_COUNT: assert property (@(posedge clk)
    rst |=> miss_count == '0); // R1
endmodule

// File: tb/corr_bpred_tb_top.sv
module corr_bpred_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_vld = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        lookup_taken;
  logic        resolve_vld = 1'b0;
  logic [31:0] resolve_pc = '0;
  logic        resolve_taken = 1'b0;
  logic [15:0] miss_count;

  always #2.5 clk = ~clk;

  corr_bpred dut_i (
    .clk(clk), .rst(rst), .lookup_vld(lookup_vld), .lookup_pc(lookup_pc),
    .lookup_taken(lookup_taken), .resolve_vld(resolve_vld), .resolve_pc(resolve_pc),
    .resolve_taken(resolve_taken), .miss_count(miss_count)
  );

  // behavioural reference
  bit m_tab[16][2];
  bit m_hist;
  int m_miss;
  int n_chk = 0;
  int n_bad = 0;

  function automatic bit ref_guess(input logic [31:0] pc);
    return m_tab[(pc >> 2) % 16][m_hist];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ref_clear();
    foreach (m_tab[i, j]) m_tab[i][j] = 1'b0;
    m_hist = 1'b0;
    m_miss = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lookup_vld = 1'b0; resolve_vld = 1'b0;
    @(posedge clk);
    ref_clear();
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one cycle: drive, compare, then advance the reference after the edge
  task automatic step(input bit lv, input logic [31:0] lpc, input bit rv,
                      input logic [31:0] rpc, input bit rt, input string tag);
    @(negedge clk);
    lookup_vld = lv; lookup_pc = lpc;
    resolve_vld = rv; resolve_pc = rpc; resolve_taken = rt;
    #1;
    chk({tag, " lookup"}, int'(lookup_taken), lv ? int'(ref_guess(lpc)) : 0);
    chk({tag, " count"}, int'(miss_count), m_miss);
    @(posedge clk);
    if (rv) begin
      int r = (rpc >> 2) % 16;
      if (m_tab[r][m_hist] != rt) begin
        if (m_miss < 65535) m_miss++;
        m_tab[r][m_hist] = rt;
      end
      m_hist = rt;
    end
  endtask

  initial begin
    #(5ns * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pcs[6] = '{32'h0000_0010, 32'h0000_1010, 32'h0000_0024,
                            32'h8000_0024, 32'h0000_003C, 32'h0000_0004};
    ref_clear();
    do_reset();
    // R1: every row reads not taken after reset
    for (int i = 0; i < 16; i++) step(1, 32'(i * 4), 0, 0, 0, "R1");
    chk("R1 count", int'(miss_count), 0);

    // R4/R5: resolve 0x10 taken with history 0 -> column 0 flips
    step(0, 0, 1, 32'h10, 1, "R5");
    step(1, 32'h10, 0, 0, 0, "R4");          // history 1, column 1 still 0
    chk("R4 literal", int'(lookup_taken), 0);
    step(0, 0, 1, 32'h10, 0, "R5");          // hit on column 1, history -> 0
    step(1, 32'h10, 0, 0, 0, "R2");
    chk("R2 literal", int'(lookup_taken), 1);
    chk("R8 literal", int'(miss_count), 1);
    // R7: alias with different upper bits shares the row
    step(1, 32'hABC0_0012, 0, 0, 0, "R7");
    chk("R7 literal", int'(lookup_taken), 1);
    // R6: same-cycle lookup sees pre-resolve state
    step(1, 32'h10, 1, 32'h10, 0, "R6");
    chk("R6 literal", int'(lookup_taken), 1);
    // R2: lookup_vld low masks the output
    step(0, 32'h10, 0, 0, 0, "R2");
    // R3: history from an unrelated branch steers the column
    step(0, 0, 1, 32'h30, 1, "R3");
    step(1, 32'h10, 0, 0, 0, "R3");

    // mixed traffic with aliasing PCs
    for (int i = 0; i < 600; i++) begin
      int a = $urandom_range(0, 5);
      int b = $urandom_range(0, 5);
      step($urandom_range(0, 1) == 1, pcs[a], $urandom_range(0, 2) != 0, pcs[b],
           $urandom_range(0, 1) == 1, "R2");
    end

    // R9: force a miss on every resolve until the count saturates
    for (int i = 0; i < 65600; i++) begin
      logic [31:0] p = pcs[i % 6];
      step(1, p, 1, p, ~ref_guess(p), "R9");
    end
    @(negedge clk); #1;
    chk("R9 literal", int'(miss_count), 65535);

    // R1: reset mid-run clears everything
    do_reset();
    #1;
    chk("R1 count after reset", int'(miss_count), 0);
    for (int i = 0; i < 16; i++) step(1, 32'(i * 4), 0, 0, 0, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule